// File: doc/BRIEF.md
# DDC Output Word Formatter

This block sits at the end of a digital down-converter channel pair. When `sample_valid` is asserted, it takes four 32-bit two's complement samples: the I and Q words of channel A and channel B. It converts each sample to the output format chosen by `fmt_sel`. The choices are 8-bit truncation, 16-bit or 24-bit rounding with saturation, full 32-bit width, or a 12-bit floating-point code. The floating-point code has an 8-bit signed mantissa and a 4-bit exponent.

The formatted words are held until the next sample. They can be read through a 16-bit parallel port, where a 3-bit select chooses one half of one word. They are also sent through a bit-serial port. Each serial frame starts with a one-bit frame sync and then carries all four words, MSB first.

The serial bit clock comes either from the master clock through a programmable divider or from an external clock pin. The ready, serial clock and frame sync outputs each have their own polarity control. The pad drivers themselves are outside this block; it only provides the output-enable flags for them.

Top module: `ddc_out_fmt`

## Requirements
- R1: With `fmt_sel`=0, each word is the top 8 bits of the sample (sample arithmetically shifted right by 24), sign-extended to 32 bits.
- R2: With `fmt_sel`=1, each word is (sample + 2^15) arithmetically shifted right by 16, sign-extended. If the result would exceed +32767, the word is 32'h00007FFF instead.
- R3: With `fmt_sel`=2, each word is (sample + 2^7) arithmetically shifted right by 8, sign-extended. If the result would exceed 2^23-1, the word is 32'h007FFFFF.
- R4: With `fmt_sel`=3, and also with the unused codes 5 to 7, each word equals the 32-bit sample unchanged.
- R5: With `fmt_sel`=4, the exponent E counts the bits directly below the sign bit that equal it, capped at 15. The mantissa is bits [31:24] of (sample << E). The word is {sign-extended mantissa, E}, with the mantissa in bits [11:4] and E in bits [3:0].
- R6: `pout` shows one half of a held word. Select bit 2 picks the channel (0=A, 1=B), bit 1 picks I (0) or Q (1), and bit 0 picks the high (0) or low (1) 16 bits. Formatted words become visible in the cycle after `sample_valid`. `pout_oe` follows `pout_en`.
- R7: `rdy` is active for exactly one cycle, the cycle after `sample_valid`. It is active high when `rdy_inv`=0 and active low when `rdy_inv`=1.
- R8: `ser_oe` is 0 from reset. One cycle after a change, it follows `ser_en`.
- R9: Each sample starts one serial frame. First comes one bit period with frame sync active. Then A-I, A-Q, B-I and B-Q follow, each MSB first, with the word width set by the format: 8, 16, 24, 32, or 12 bits.
- R10: With `sck_ext`=0, the serial clock period is 2*(`sck_div`+1) master clocks. With `sck_ext`=1, the serial clock follows `sck_in`.
- R11: `sck_inv` and `sfs_inv` each invert their output. Serial data still updates at the falling edge of the non-inverted clock.

Ports of `ddc_out_fmt`, in port-list order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_valid | input | 1 | New decimated sample present, starts an output period |
| a_i | input | 32 | Channel A in-phase sample |
| a_q | input | 32 | Channel A quadrature sample |
| b_i | input | 32 | Channel B in-phase sample |
| b_q | input | 32 | Channel B quadrature sample |
| fmt_sel | input | 3 | Output format code |
| ser_en | input | 1 | Serial port enable |
| rdy_inv | input | 1 | Ready polarity |
| sck_inv | input | 1 | Serial clock polarity |
| sfs_inv | input | 1 | Frame sync polarity |
| sck_ext | input | 1 | Use external bit clock |
| sck_div | input | DIV_W | Internal bit clock divider |
| sck_in | input | 1 | External bit clock |
| pout_sel | input | 3 | Parallel word/half select |
| pout_en | input | 1 | Parallel driver enable request |
| rdy | output | 1 | Output period start pulse |
| ser_oe | output | 1 | Serial pad enable flag |
| sck | output | 1 | Serial bit clock |
| sfs | output | 1 | Serial frame sync |
| sd | output | 1 | Serial data |
| pout | output | 16 | Parallel output word half |
| pout_oe | output | 1 | Parallel pad enable flag |

## Verification
The assertions check several properties on every cycle. The ready pulse must follow each sample by one cycle, last one cycle and honour its polarity. The serial enable flag must track its configuration bit. Every formatted word must fit its format's signed range, which means saturation never lets a rounded word wrap.

Other behaviour can only be shown by the bench's scenarios. These include the exact rounding, saturation and exponent values, and the parallel select decoding. They also include the serial frame contents and word order for each format width, the divided and external bit clock periods, and decoding a frame with all polarities inverted.

// File: rtl/ddc_fmt_pkg.sv
`timescale 1ns/1ps
package ddc_fmt_pkg;
    localparam int DW = 32;
    localparam int NWORD = 4;

    localparam logic [2:0] FMT_T8   = 3'd0;
    localparam logic [2:0] FMT_R16  = 3'd1;
    localparam logic [2:0] FMT_R24  = 3'd2;
    localparam logic [2:0] FMT_T32  = 3'd3;
    localparam logic [2:0] FMT_FP12 = 3'd4;

    typedef enum logic [1:0] {TX_IDLE, TX_PEND, TX_SYNC, TX_SHIFT} tx_st_e;

    typedef struct packed {
        tx_st_e                      st;
        logic [1:0]                  wsel;
        logic [4:0]                  bidx;
        logic [5:0]                  width;
        logic [NWORD-1:0][DW-1:0]    sh;
        logic                        sfs;
        logic                        sd;
    } tx_t;

    typedef struct packed {
        logic [NWORD-1:0][DW-1:0]    words;
        logic                        rdy;
        logic                        oe;
    } hold_t;

    function automatic logic [5:0] fmt_bits(input logic [2:0] f);
        case (f)
            FMT_T8:   fmt_bits = 6'd8;
            FMT_R16:  fmt_bits = 6'd16;
            FMT_R24:  fmt_bits = 6'd24;
            FMT_FP12: fmt_bits = 6'd12;
            default:  fmt_bits = 6'd32;
        endcase
    endfunction
endpackage

// File: rtl/ddc_word_fmt.sv
`timescale 1ns/1ps
module ddc_word_fmt
    import ddc_fmt_pkg::*;
(
    input  logic [DW-1:0] x,
    input  logic [2:0]    fmt,
    output logic [DW-1:0] y
);
    logic [16:0] r16_d;
    logic [24:0] r24_d;
    logic [3:0]  exp_d;
    logic        run_d;
    logic [7:0]  man_d;

    always_comb begin
        // round half up: add the first dropped bit into the kept part
        r16_d = {x[31], x[31:16]} + {16'd0, x[15]};
        r24_d = {x[31], x[31:8]}  + {24'd0, x[7]};
        exp_d = '0;
        run_d = 1'b1;
        for (int i = 30; i >= 16; i--) begin
            if (run_d && (x[i] == x[31])) exp_d = exp_d + 4'd1;
            else                          run_d = 1'b0;
        end
        man_d = x[5'd31 - {1'b0, exp_d} -: 8];
        case (fmt)
            FMT_T8:   y = {{24{x[31]}}, x[31:24]};
            FMT_R16:  y = (r16_d[16] != r16_d[15]) ? 32'h0000_7FFF
                                                   : {{16{r16_d[15]}}, r16_d[15:0]};
            FMT_R24:  y = (r24_d[24] != r24_d[23]) ? 32'h007F_FFFF
                                                   : {{8{r24_d[23]}}, r24_d[23:0]};
            FMT_FP12: y = {{20{man_d[7]}}, man_d, exp_d};
            default:  y = x;
        endcase
    end
endmodule

// File: rtl/ddc_sck_gen.sv
`timescale 1ns/1ps
module ddc_sck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_sel,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    output logic             sck_raw,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             s1;
        logic             s2;
        logic             s3;
    } sg_t;

    sg_t q, d;
    logic wrap_d;

    always_comb begin
        d      = q;
        d.s1   = sck_in;
        d.s2   = q.s1;
        d.s3   = q.s2;
        wrap_d = (q.cnt >= div);
        if (wrap_d) begin
            d.cnt = '0;
            d.sck = ~q.sck;
        end else begin
            d.cnt = q.cnt + 1'b1;
        end
        sck_raw = ext_sel ? q.s2 : q.sck;
        tick    = ext_sel ? (q.s3 & ~q.s2) : (wrap_d & q.sck);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/ddc_ser_tx.sv
`timescale 1ns/1ps
module ddc_ser_tx
    import ddc_fmt_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load,
    input  logic                     tick,
    input  logic [2:0]               fmt,
    input  logic [NWORD-1:0][DW-1:0] words,
    output logic                     sfs_raw,
    output logic                     sd
);
    tx_t        q, d;
    logic [5:0] w_d;

    always_comb begin
        d   = q;
        w_d = fmt_bits(fmt);
        if (load) begin
            for (int k = 0; k < NWORD; k++) d.sh[k] = words[k] << (6'd32 - w_d);
            d.width = w_d;
            d.st    = TX_PEND;
            d.sfs   = 1'b0;
            d.sd    = 1'b0;
        end else if (tick) begin
            case (q.st)
                TX_PEND: begin
                    d.sfs = 1'b1;
                    d.st  = TX_SYNC;
                end
                TX_SYNC: begin
                    d.sfs  = 1'b0;
                    d.wsel = 2'd0;
                    d.bidx = 5'd0;
                    d.sd   = q.sh[0][31];
                    d.st   = TX_SHIFT;
                end
                TX_SHIFT: begin
                    if (q.bidx == 5'(q.width - 6'd1)) begin
                        if (q.wsel == 2'd3) begin
                            d.st = TX_IDLE;
                            d.sd = 1'b0;
                        end else begin
                            d.wsel = q.wsel + 2'd1;
                            d.bidx = 5'd0;
                            d.sd   = q.sh[q.wsel + 2'd1][31];
                        end
                    end else begin
                        d.bidx = q.bidx + 5'd1;
                        d.sd   = q.sh[q.wsel][5'd30 - q.bidx];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sfs_raw = q.sfs;
    assign sd      = q.sd;
endmodule

// File: rtl/ddc_out_fmt.sv
`timescale 1ns/1ps
module ddc_out_fmt
    import ddc_fmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic [31:0]      a_i,
    input  logic [31:0]      a_q,
    input  logic [31:0]      b_i,
    input  logic [31:0]      b_q,
    input  logic [2:0]       fmt_sel,
    input  logic             ser_en,
    input  logic             rdy_inv,
    input  logic             sck_inv,
    input  logic             sfs_inv,
    input  logic             sck_ext,
    input  logic [DIV_W-1:0] sck_div,
    input  logic             sck_in,
    input  logic [2:0]       pout_sel,
    input  logic             pout_en,
    output logic             rdy,
    output logic             ser_oe,
    output logic             sck,
    output logic             sfs,
    output logic             sd,
    output logic [15:0]      pout,
    output logic             pout_oe
);
    localparam int HW = DW / 2;

    logic [NWORD-1:0][DW-1:0] raw;
    logic [NWORD-1:0][DW-1:0] fw;
    logic                     sck_raw, bit_tick, sfs_raw;
    hold_t                    q, d;
    logic [DW-1:0]            sel_word;

    assign raw = {b_q, b_i, a_q, a_i};

    for (genvar g = 0; g < NWORD; g++) begin : g_fmt
        ddc_word_fmt u_fmt (.x(raw[g]), .fmt(fmt_sel), .y(fw[g]));
    end

    ddc_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk(clk), .rst_n(rst_n), .ext_sel(sck_ext), .div(sck_div),
        .sck_in(sck_in), .sck_raw(sck_raw), .tick(bit_tick)
    );

    ddc_ser_tx u_tx (
        .clk(clk), .rst_n(rst_n), .load(sample_valid), .tick(bit_tick),
        .fmt(fmt_sel), .words(fw), .sfs_raw(sfs_raw), .sd(sd)
    );

    always_comb begin
        d     = q;
        d.rdy = sample_valid;
        d.oe  = ser_en;
        if (sample_valid) d.words = fw;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        sel_word = q.words[pout_sel[2:1]];
        pout     = pout_sel[0] ? sel_word[HW-1:0] : sel_word[DW-1:HW];
    end

    assign pout_oe = pout_en;
    assign rdy     = q.rdy ^ rdy_inv;
    assign ser_oe  = q.oe;
    assign sck     = sck_raw ^ sck_inv;
    assign sfs     = sfs_raw ^ sfs_inv;
endmodule

// File: rtl/ddc_out_fmt_chk.sv
`timescale 1ns/1ps
module ddc_out_fmt_chk (
    input logic             clk,
    input logic             rst_n,
    input logic             sample_valid,
    input logic             rdy,
    input logic             rdy_inv,
    input logic             ser_en,
    input logic             ser_oe,
    input logic [2:0]       fmt_sel,
    input logic [3:0][31:0] fw
);
    function automatic logic fits(input logic [3:0][31:0] w, input int b);
        fits = 1'b1;
        for (int k = 0; k < 4; k++) begin
            logic signed [31:0] s;
            s = $signed(w[k]) >>> b;
            if ((s != 0) && (s != -1)) fits = 1'b0;
        end
    endfunction

    a_r7_rdy_follows: assert property (@(posedge clk) disable iff (!rst_n)
        sample_valid |=> (rdy != rdy_inv));
    a_r7_rdy_single: assert property (@(posedge clk) disable iff (!rst_n)
        ((rdy != rdy_inv) && !sample_valid) |=> (rdy == rdy_inv));
    a_r8_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_en |=> !ser_oe);
    a_r8_oe_on: assert property (@(posedge clk) disable iff (!rst_n)
        ser_en |=> ser_oe);
    a_r1_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd0) |-> fits(fw, 7));
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd1) |-> fits(fw, 15));
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd2) |-> fits(fw, 23));
    a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_sel == 3'd4) |-> fits(fw, 11));
endmodule

bind ddc_out_fmt ddc_out_fmt_chk u_chk (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rdy(rdy),
    .rdy_inv(rdy_inv), .ser_en(ser_en), .ser_oe(ser_oe),
    .fmt_sel(fmt_sel), .fw(fw)
);

// File: tb/ddc_out_fmt_test.sv
`timescale 1ns/1ps
module ddc_out_fmt_test;
    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 1200;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [31:0] a_i = '0, a_q = '0, b_i = '0, b_q = '0;
    logic [2:0]  fmt_sel = '0;
    logic        ser_en = 1'b0, rdy_inv = 1'b0, sck_inv = 1'b0, sfs_inv = 1'b0;
    logic        sck_ext = 1'b0;
    logic [7:0]  sck_div = 8'd1;
    logic        sck_in = 1'b0;
    logic [2:0]  pout_sel = '0;
    logic        pout_en = 1'b0;
    logic        rdy, ser_oe, sck, sfs, sd, pout_oe;
    logic [15:0] pout;

    int checks = 0, errors = 0, frames_sent = 0, frames_seen = 0, cycles = 0;
    bit done = 0, ext_run = 0;

    logic [31:0] exp_q[$];
    int          wid_q[$];

    ddc_out_fmt uut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .a_i(a_i), .a_q(a_q), .b_i(b_i), .b_q(b_q), .fmt_sel(fmt_sel),
        .ser_en(ser_en), .rdy_inv(rdy_inv), .sck_inv(sck_inv), .sfs_inv(sfs_inv),
        .sck_ext(sck_ext), .sck_div(sck_div), .sck_in(sck_in),
        .pout_sel(pout_sel), .pout_en(pout_en), .rdy(rdy), .ser_oe(ser_oe),
        .sck(sck), .sfs(sfs), .sd(sd), .pout(pout), .pout_oe(pout_oe)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int wid(input logic [2:0] f);
        case (f)
            3'd0: return 8;
            3'd1: return 16;
            3'd2: return 24;
            3'd4: return 12;
            default: return 32;
        endcase
    endfunction

    function automatic logic [31:0] ref_fmt(input logic [31:0] x, input logic [2:0] f);
        longint v;
        logic [31:0] s;
        int e;
        case (f)
            3'd0: return 32'($signed(x) >>> 24);
            3'd1: begin
                v = (longint'($signed(x)) + 64'sd32768) >>> 16;
                if (v > 32767) v = 32767;
                return v[31:0];
            end
            3'd2: begin
                v = (longint'($signed(x)) + 64'sd128) >>> 8;
                if (v > 8388607) v = 8388607;
                return v[31:0];
            end
            3'd4: begin
                s = x; e = 0;
                while (e < 15 && s[31] == s[30]) begin s = s << 1; e++; end
                return {{20{s[31]}}, s[31:24], 4'(e)};
            end
            default: return x;
        endcase
    endfunction

    // driver: computes expected words, pushes the frame, checks ready and parallel port
    task automatic send(input logic [31:0] ai, input logic [31:0] aq,
                        input logic [31:0] bi, input logic [31:0] bq, input string req);
        logic [31:0] e[4];
        e[0] = ref_fmt(ai, fmt_sel); e[1] = ref_fmt(aq, fmt_sel);
        e[2] = ref_fmt(bi, fmt_sel); e[3] = ref_fmt(bq, fmt_sel);
        for (int k = 0; k < 4; k++) exp_q.push_back(e[k]);
        wid_q.push_back(wid(fmt_sel));
        frames_sent++;
        @(negedge clk);
        a_i = ai; a_q = aq; b_i = bi; b_q = bq; sample_valid = 1'b1;
        @(negedge clk);
        sample_valid = 1'b0;
        chk(rdy == ~rdy_inv, "R7 ready active", {31'd0, rdy}, {31'd0, ~rdy_inv});
        for (int p = 0; p < 8; p++) begin
            pout_sel = 3'(p);
            #1;
            chk(pout == (p[0] ? e[p/2][15:0] : e[p/2][31:16]),
                $sformatf("%s / R6 sel %0d", req, p), {16'd0, pout},
                {16'd0, (p[0] ? e[p/2][15:0] : e[p/2][31:16])});
        end
        @(negedge clk);
        chk(rdy == rdy_inv, "R7 ready one cycle", {31'd0, rdy}, {31'd0, rdy_inv});
        repeat (GAP) @(negedge clk);
    endtask

    // monitor: decodes serial frames on rising bit clock edges, compares against scoreboard
    initial begin
        bit prev = 0, coll = 0;
        int w = 0, nb = 0, wk = 0;
        logic [31:0] cur = '0, ex, mask;
        forever begin
            @(negedge clk);
            if (((sck ^ sck_inv) == 1'b1) && !prev) begin
                if (coll) begin
                    cur = {cur[30:0], sd};
                    nb++;
                    if (nb == w) begin
                        ex   = exp_q.pop_front();
                        mask = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
                        chk((cur & mask) == (ex & mask), $sformatf("R9 serial word %0d", wk),
                            cur & mask, ex & mask);
                        nb = 0; cur = '0; wk++;
                        if (wk == 4) begin coll = 0; frames_seen++; end
                    end
                end else if ((sfs ^ sfs_inv) == 1'b1) begin
                    if (wid_q.size() == 0) chk(1'b0, "R9 unexpected frame", 32'd1, 32'd0);
                    else begin
                        w = wid_q.pop_front(); coll = 1; nb = 0; wk = 0; cur = '0;
                    end
                end
            end
            prev = sck ^ sck_inv;
        end
    end

    // external bit clock source
    initial begin
        forever begin
            repeat (4) @(negedge clk);
            if (ext_run) sck_in = ~sck_in;
        end
    end

    task automatic meas(output int p);
        bit pv;
        p = 0;
        pv = sck ^ sck_inv;
        forever begin
            @(negedge clk);
            if ((sck ^ sck_inv) && !pv) break;
            pv = sck ^ sck_inv;
        end
        pv = 1;
        forever begin
            @(negedge clk);
            p++;
            if ((sck ^ sck_inv) && !pv) break;
            pv = sck ^ sck_inv;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                chk(1'b0, "watchdog", 32'(cycles), 32'(WATCHDOG));
                finish_run();
            end
        end
    end

    initial begin
        int per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R8 reset oe", {31'd0, ser_oe}, 32'd0);
        chk(rdy == 1'b0, "R7 reset rdy", {31'd0, rdy}, 32'd0);
        chk(pout == 16'd0, "R6 reset pout", {16'd0, pout}, 32'd0);
        chk(sfs == 1'b0, "R9 reset sfs", {31'd0, sfs}, 32'd0);
        repeat (5) @(negedge clk);
        chk(ser_oe == 1'b0, "R8 stays off", {31'd0, ser_oe}, 32'd0);
        ser_en = 1'b1; pout_en = 1'b1;
        @(negedge clk);
        chk(ser_oe == 1'b1, "R8 enabled", {31'd0, ser_oe}, 32'd1);
        chk(pout_oe == 1'b1, "R6 pout_oe", {31'd0, pout_oe}, 32'd1);

        // R10 internal divider period
        sck_div = 8'd2;
        repeat (20) @(negedge clk);
        meas(per);
        chk(per == 6, "R10 div period", 32'(per), 32'd6);
        sck_div = 8'd1;
        repeat (20) @(negedge clk);

        fmt_sel = 3'd0;
        send(32'h1234_5678, 32'h8765_4321, 32'hFFFF_FFFF, 32'h7FFF_FFFF, "R1");
        fmt_sel = 3'd1;
        send(32'h7FFF_8000, 32'h1234_8000, 32'hFFFF_7FFF, 32'h8000_0000, "R2");
        send(32'h0000_7FFF, 32'hFFFF_8000, 32'h7FFF_7FFF, 32'h0001_0000, "R2");
        fmt_sel = 3'd2;
        send(32'h7FFF_FF80, 32'h0000_0180, 32'hFFFF_FF7F, 32'h8000_0000, "R3");
        fmt_sel = 3'd3;
        send(32'hDEAD_BEEF, 32'h0123_4567, 32'h8000_0000, 32'h7FFF_FFFF, "R4");
        fmt_sel = 3'd6;
        send(32'hCAFE_F00D, 32'h0000_0001, 32'hFFFF_0000, 32'h5555_AAAA, "R4 reserved");
        fmt_sel = 3'd4;
        send(32'h0001_0000, 32'hFFFF_FFFF, 32'h1234_5678, 32'h0000_0000, "R5");
        send(32'h8000_0000, 32'hC000_1234, 32'h0000_00FF, 32'hFFFE_0000, "R5");

        // R11 polarities
        rdy_inv = 1'b1; sfs_inv = 1'b1; sck_inv = 1'b1;
        repeat (3) @(negedge clk);
        chk(rdy == 1'b1, "R11/R7 rdy idle inverted", {31'd0, rdy}, 32'd1);
        chk(sfs == 1'b1, "R11 sfs idle inverted", {31'd0, sfs}, 32'd1);
        fmt_sel = 3'd1;
        send(32'h4444_8000, 32'hABCD_0000, 32'h0F0F_0F0F, 32'hF0F0_F0F0, "R11");
        rdy_inv = 1'b0; sfs_inv = 1'b0; sck_inv = 1'b0;

        // R10 external bit clock
        sck_ext = 1'b1; ext_run = 1;
        repeat (30) @(negedge clk);
        meas(per);
        chk(per == 8, "R10 ext period", 32'(per), 32'd8);
        fmt_sel = 3'd3;
        send(32'h9ABC_DEF0, 32'h1357_9BDF, 32'h2468_ACE0, 32'hFEDC_BA98, "R10 ext");
        repeat (GAP) @(negedge clk);

        chk(frames_seen == frames_sent, "R9 frame count", 32'(frames_seen), 32'(frames_sent));
        ser_en = 1'b0;
        @(negedge clk);
        chk(ser_oe == 1'b0, "R8 disabled", {31'd0, ser_oe}, 32'd0);
        finish_run();
    end
endmodule